// File: doc/BRIEF.md
# Trace-Level Stride Prediction Updater

This block holds a short in-order queue of prediction records. Each record covers one fetched trace of up to `SLOTS` instruction slots. For every slot the record keeps a predicted result, a signed stride, the most recently observed delta and a saturating confidence counter. A record is pushed when its trace is renamed. It waits until the trace's instructions retire. At retirement the oldest record is popped and compared slot by slot with the actual results.

For each live slot the block updates the confidence counter and the stride, then forms the next predicted value. It emits the whole refreshed record for storage one cycle later. There is no table indexed by instruction address: all learning happens on the buffered records.

Slots outside the valid mask, and slots flagged as wrong-path at retirement, pass through untouched. A parameter selects one of two stride policies. The plain policy always adopts the newest delta. The two-delta policy adopts a new delta only when it repeats the previous one.

Top module: `stride_trace_updater`

## Requirements
- R1: After reset the queue is empty: `enq_ready` is 1, `ret_ready` is 0 and `out_valid` is 0.
- R2: Retirement always consumes the oldest queued record, so records come out in the order they were pushed.
- R3: The queue holds `DEPTH` (32) records. When it is full, `enq_ready` is 0, and a push offered then leaves the queued records and their count unchanged.
- R4: For a live slot, the 2-bit confidence rises by one when the actual value equals the predicted value and falls by one otherwise. It stays at 3 on a hit at 3 and at 0 on a miss at 0.
- R5: `out_use[i]` is 1 exactly when slot i is marked valid in the record and its output confidence is greater than 2.
- R6: With `TWO_DELTA`=0, for a live slot the observed delta d is the low 16 bits of actual − (predicted − sext(stride)). The output stride and output last-delta both become d, and the output value is actual + sext(d), taken modulo 2^32.
- R7: With `TWO_DELTA`=1, the output stride becomes d only if d equals the stored last-delta, and otherwise keeps its old value. The output last-delta always becomes d, and the output value is actual + sext(output stride).
- R8: A slot whose mask bit (bit i of `enq_mask`) is 0, or whose `ret_wrong[i]` bit is 1, is emitted with its stored value, stride, last-delta and confidence unchanged.
- R9: A retirement accepted at a clock edge (`ret_valid` and `ret_ready`) makes `out_valid` 1 for exactly the following cycle, carrying the refreshed record. A `ret_valid` offered while the queue is empty produces no output.
- R10: A push and a retirement in the same cycle are both accepted when the queue is neither full nor empty, and the record count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push request for a record |
| enq_ready | output | 1 | Queue can take a record |
| enq_pred | input | SLOTS*VW | Predicted values, slot i at bits [i*VW +: VW] |
| enq_stride | input | SLOTS*SW | Signed strides per slot |
| enq_delta | input | SLOTS*SW | Last observed delta per slot |
| enq_conf | input | SLOTS*CW | Confidence counters per slot |
| enq_mask | input | SLOTS | Slot holds a result-producing instruction |
| ret_valid | input | 1 | Retirement of the oldest trace |
| ret_ready | output | 1 | Queue holds at least one record |
| ret_actual | input | SLOTS*VW | Actual retired results per slot |
| ret_wrong | input | SLOTS | Slot belongs to the wrong path |
| out_valid | output | 1 | Refreshed record present |
| out_value | output | SLOTS*VW | Next predicted values |
| out_stride | output | SLOTS*SW | Updated strides |
| out_delta | output | SLOTS*SW | Updated last-deltas |
| out_conf | output | SLOTS*CW | Updated confidences |
| out_mask | output | SLOTS | Slot mask carried through |
| out_use | output | SLOTS | Slot may be used speculatively |

## Verification
The assertions assume that the retire inputs are known whenever `ret_valid` is high. They also assume that the slot fields are stable at the edge where a push or a retirement is taken. The stimulus changes every input only at the falling edge and holds it across the next rising edge. The one exception is that the bench drives `ret_valid` into an empty queue on purpose, to show that it is ignored. The bench also keeps the wrong-path mask at zero unless a scenario sets it deliberately, so the pass-through property is exercised only where it is intended.

// File: rtl/stride_trace_updater.sv
module stride_trace_updater #(
  parameter int SLOTS     = 16,
  parameter int DEPTH     = 32,
  parameter int VW        = 32,
  parameter int SW        = 16,
  parameter int CW        = 2,
  parameter bit TWO_DELTA = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  output logic                enq_ready,
  input  logic [SLOTS*VW-1:0] enq_pred,
  input  logic [SLOTS*SW-1:0] enq_stride,
  input  logic [SLOTS*SW-1:0] enq_delta,
  input  logic [SLOTS*CW-1:0] enq_conf,
  input  logic [SLOTS-1:0]    enq_mask,
  input  logic                ret_valid,
  output logic                ret_ready,
  input  logic [SLOTS*VW-1:0] ret_actual,
  input  logic [SLOTS-1:0]    ret_wrong,
  output logic                out_valid,
  output logic [SLOTS*VW-1:0] out_value,
  output logic [SLOTS*SW-1:0] out_stride,
  output logic [SLOTS*SW-1:0] out_delta,
  output logic [SLOTS*CW-1:0] out_conf,
  output logic [SLOTS-1:0]    out_mask,
  output logic [SLOTS-1:0]    out_use
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL   = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH-1);
  localparam logic [CW-1:0] CMAX   = {CW{1'b1}};
  localparam logic [CW-1:0] CTHRESH = CW'(2);

  logic [SLOTS*VW-1:0] q_val  [DEPTH];
  logic [SLOTS*SW-1:0] q_str  [DEPTH];
  logic [SLOTS*SW-1:0] q_dlt  [DEPTH];
  logic [SLOTS*CW-1:0] q_conf [DEPTH];
  logic [SLOTS-1:0]    q_mask [DEPTH];

  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign enq_ready = (cnt != FULL);
  assign ret_ready = (cnt != '0);

  wire enq_fire = enq_valid && enq_ready;
  wire ret_fire = ret_valid && ret_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (enq_fire) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (ret_fire) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(enq_fire) - (AW+1)'(ret_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (enq_fire) begin
      q_val[wp]  <= enq_pred;
      q_str[wp]  <= enq_stride;
      q_dlt[wp]  <= enq_delta;
      q_conf[wp] <= enq_conf;
      q_mask[wp] <= enq_mask;
    end
  end

  wire [SLOTS*VW-1:0] rd_val  = q_val[rp];
  wire [SLOTS*SW-1:0] rd_str  = q_str[rp];
  wire [SLOTS*SW-1:0] rd_dlt  = q_dlt[rp];
  wire [SLOTS*CW-1:0] rd_conf = q_conf[rp];
  wire [SLOTS-1:0]    rd_mask = q_mask[rp];

  logic [SLOTS*VW-1:0] nx_val;
  logic [SLOTS*SW-1:0] nx_str, nx_dlt;
  logic [SLOTS*CW-1:0] nx_conf;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    wire [VW-1:0] pv   = rd_val[i*VW +: VW];
    wire [SW-1:0] st   = rd_str[i*SW +: SW];
    wire [SW-1:0] ld   = rd_dlt[i*SW +: SW];
    wire [CW-1:0] cf   = rd_conf[i*CW +: CW];
    wire [VW-1:0] act  = ret_actual[i*VW +: VW];
    wire          live = rd_mask[i] && !ret_wrong[i];
    wire          hit  = (act == pv);
    wire [CW-1:0] cf_n = hit ? ((cf == CMAX) ? cf : cf + 1'b1)
                             : ((cf == '0)   ? cf : cf - 1'b1);
    wire [VW-1:0] prev = pv - {{(VW-SW){st[SW-1]}}, st};
    wire [VW-1:0] obs  = act - prev;
    wire [SW-1:0] d    = obs[SW-1:0];
    logic [SW-1:0] st_n;
    if (TWO_DELTA) begin : g_two
      assign st_n = (d == ld) ? d : st;
    end else begin : g_one
      assign st_n = d;
    end
    wire [VW-1:0] nv = act + {{(VW-SW){st_n[SW-1]}}, st_n};
    assign nx_val[i*VW +: VW]  = live ? nv   : pv;
    assign nx_str[i*SW +: SW]  = live ? st_n : st;
    assign nx_dlt[i*SW +: SW]  = live ? d    : ld;
    assign nx_conf[i*CW +: CW] = live ? cf_n : cf;
    assign out_use[i] = out_mask[i] && (out_conf[i*CW +: CW] > CTHRESH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_value  <= '0;
      out_stride <= '0;
      out_delta  <= '0;
      out_conf   <= '0;
      out_mask   <= '0;
    end else begin
      out_valid <= ret_fire;
      if (ret_fire) begin
        out_value  <= nx_val;
        out_stride <= nx_str;
        out_delta  <= nx_dlt;
        out_conf   <= nx_conf;
        out_mask   <= rd_mask;
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_refused_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready && !ret_valid) |=> (cnt == $past(cnt)));

  p_pair_keeps_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && ret_valid && ret_ready) |=> (cnt == $past(cnt)));

  p_wrong_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(ret_wrong[0])) |->
      (out_value[VW-1:0] == $past(rd_val[VW-1:0]) &&
       out_conf[CW-1:0] == $past(rd_conf[CW-1:0])));

  p_conf_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rd_mask[0] && !ret_wrong[0])) |->
      ((int'(out_conf[CW-1:0]) - int'($past(rd_conf[CW-1:0])) <= 1) &&
       (int'($past(rd_conf[CW-1:0])) - int'(out_conf[CW-1:0]) <= 1)));

  p_empty_no_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> !out_valid);
endmodule

// File: tb/sim_stride_trace_updater.sv
module sim_stride_trace_updater;
  localparam int CLK_PERIOD = 10;
  localparam int S = 16, D = 32, VW = 32, SW = 16, CW = 2;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic enq_valid = 0, ret_valid = 0;
  logic [S*VW-1:0] enq_pred = '0, ret_actual = '0;
  logic [S*SW-1:0] enq_stride = '0, enq_delta = '0;
  logic [S*CW-1:0] enq_conf = '0;
  logic [S-1:0]    enq_mask = '0, ret_wrong = '0;

  logic r0_e, r0_r, r1_e, r1_r, v0, v1;
  logic [S*VW-1:0] o0_val, o1_val;
  logic [S*SW-1:0] o0_str, o0_dlt, o1_str, o1_dlt;
  logic [S*CW-1:0] o0_cf, o1_cf;
  logic [S-1:0]    o0_m, o1_m, o0_use, o1_use;

  stride_trace_updater #(.TWO_DELTA(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(r0_e),
    .enq_pred(enq_pred), .enq_stride(enq_stride), .enq_delta(enq_delta),
    .enq_conf(enq_conf), .enq_mask(enq_mask), .ret_valid(ret_valid),
    .ret_ready(r0_r), .ret_actual(ret_actual), .ret_wrong(ret_wrong),
    .out_valid(v0), .out_value(o0_val), .out_stride(o0_str), .out_delta(o0_dlt),
    .out_conf(o0_cf), .out_mask(o0_m), .out_use(o0_use));

  stride_trace_updater #(.TWO_DELTA(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(r1_e),
    .enq_pred(enq_pred), .enq_stride(enq_stride), .enq_delta(enq_delta),
    .enq_conf(enq_conf), .enq_mask(enq_mask), .ret_valid(ret_valid),
    .ret_ready(r1_r), .ret_actual(ret_actual), .ret_wrong(ret_wrong),
    .out_valid(v1), .out_value(o1_val), .out_stride(o1_str), .out_delta(o1_dlt),
    .out_conf(o1_cf), .out_mask(o1_m), .out_use(o1_use));

  int checks = 0, failures = 0;

  logic [31:0] t_pv [S];
  logic [15:0] t_st [S], t_ld [S];
  logic [1:0]  t_cf [S];
  logic [S-1:0] t_mask;
  logic [31:0] a_act [S];

  task automatic chk(input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic make_trace(input int seed);
    for (int i = 0; i < S; i++) begin
      t_pv[i] = 32'(seed * 1000 + i * 7);
      t_st[i] = 16'((i - 8) * 2);
      t_cf[i] = 2'((i / 2) % 4);
      a_act[i] = (i % 2 == 0) ? t_pv[i] : t_pv[i] + 32'd3;
      t_ld[i] = (i % 3 == 0) ? t_st[i] + ((i % 2 == 1) ? 16'd3 : 16'd0) : 16'h1234;
    end
    t_mask = 16'hFFFF ^ 16'(seed & 16'h0101);
  endtask

  task automatic load_bus();
    for (int i = 0; i < S; i++) begin
      enq_pred[i*VW +: VW]   = t_pv[i];
      enq_stride[i*SW +: SW] = t_st[i];
      enq_delta[i*SW +: SW]  = t_ld[i];
      enq_conf[i*CW +: CW]   = t_cf[i];
    end
    enq_mask = t_mask;
  endtask

  task automatic push(input int seed);
    @(negedge clk);
    make_trace(seed);
    load_bus();
    enq_valid = 1;
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic drive_ret();
    for (int i = 0; i < S; i++) ret_actual[i*VW +: VW] = a_act[i];
    ret_valid = 1;
  endtask

  task automatic check_out(input string tag);
    logic [S*VW-1:0] e0v, e1v;
    logic [S*SW-1:0] e0s, e1s, ed;
    logic [S*CW-1:0] ec;
    logic [S-1:0]    eu;
    for (int i = 0; i < S; i++) begin
      logic live;
      logic [1:0]  c;
      logic [31:0] prev, obs, sx0, sx1;
      logic [15:0] d, s1;
      live = t_mask[i] && !ret_wrong[i];
      c = t_cf[i];
      prev = t_pv[i] - {{16{t_st[i][15]}}, t_st[i]};
      obs  = a_act[i] - prev;
      d    = obs[15:0];
      s1   = (d == t_ld[i]) ? d : t_st[i];
      sx0  = {{16{d[15]}}, d};
      sx1  = {{16{s1[15]}}, s1};
      if (live) begin
        if (a_act[i] == t_pv[i]) c = (c == 2'd3) ? c : c + 2'd1;
        else                     c = (c == 2'd0) ? c : c - 2'd1;
        e0v[i*VW +: VW] = a_act[i] + sx0;
        e1v[i*VW +: VW] = a_act[i] + sx1;
        e0s[i*SW +: SW] = d;
        e1s[i*SW +: SW] = s1;
        ed[i*SW +: SW]  = d;
      end else begin
        e0v[i*VW +: VW] = t_pv[i];
        e1v[i*VW +: VW] = t_pv[i];
        e0s[i*SW +: SW] = t_st[i];
        e1s[i*SW +: SW] = t_st[i];
        ed[i*SW +: SW]  = t_ld[i];
      end
      ec[i*CW +: CW] = c;
      eu[i] = t_mask[i] && (c == 2'd3);
    end
    chk("R9", {tag, " out_valid"}, 512'({v0, v1}), 512'(2'b11));
    chk(tag, "u0 value", 512'(o0_val), 512'(e0v));
    chk(tag, "u0 stride", 512'(o0_str), 512'(e0s));
    chk(tag, "u0 delta", 512'(o0_dlt), 512'(ed));
    chk("R6", {tag, " u0 value"}, 512'(o0_val), 512'(e0v));
    chk("R7", {tag, " u1 value"}, 512'(o1_val), 512'(e1v));
    chk("R7", {tag, " u1 stride"}, 512'(o1_str), 512'(e1s));
    chk("R7", {tag, " u1 delta"}, 512'(o1_dlt), 512'(ed));
    chk("R4", {tag, " conf"}, 512'(o0_cf), 512'(ec));
    chk("R4", {tag, " u1 conf"}, 512'(o1_cf), 512'(ec));
    chk("R5", {tag, " use"}, 512'(o0_use), 512'(eu));
    chk("R8", {tag, " mask"}, 512'(o0_m), 512'(t_mask));
  endtask

  task automatic pull(input int seed, input string tag);
    @(negedge clk);
    make_trace(seed);
    drive_ret();
    @(negedge clk);
    ret_valid = 0;
    check_out(tag);
    @(negedge clk);
    chk("R9", {tag, " single pulse"}, 512'({v0, v1}), 512'(0));
  endtask

  task automatic t_reset();
    chk("R1", "enq_ready", 512'({r0_e, r1_e}), 512'(2'b11));
    chk("R1", "ret_ready", 512'({r0_r, r1_r}), 512'(0));
    chk("R1", "out_valid", 512'({v0, v1}), 512'(0));
  endtask

  task automatic t_basic();
    push(5);
    pull(5, "R6");
  endtask

  task automatic t_wrong();
    push(3);
    ret_wrong = 16'h00F0;
    pull(3, "R8");
    ret_wrong = '0;
  endtask

  task automatic t_order();
    push(11); push(12); push(13);
    pull(11, "R2");
    pull(12, "R2");
    pull(13, "R2");
    chk("R2", "empty after drain", 512'(r0_r), 512'(0));
  endtask

  task automatic t_full();
    for (int k = 0; k < D; k++) push(100 + k);
    chk("R3", "ready low when full", 512'({r0_e, r1_e}), 512'(0));
    push(999);
    chk("R3", "still full after refused push", 512'({r0_e, r1_e}), 512'(0));
    for (int k = 0; k < D; k++) pull(100 + k, "R3");
    chk("R3", "empty after 32 pulls", 512'({r0_r, r1_r}), 512'(0));
    @(negedge clk);
    ret_valid = 1;
    @(negedge clk);
    ret_valid = 0;
    chk("R9", "no output from empty retire", 512'({v0, v1}), 512'(0));
    chk("R9", "queue stays empty", 512'({r0_r, r1_r}), 512'(0));
  endtask

  task automatic t_pair();
    push(200);
    @(negedge clk);
    make_trace(201);
    load_bus();
    enq_valid = 1;
    make_trace(200);
    drive_ret();
    @(negedge clk);
    enq_valid = 0;
    ret_valid = 0;
    check_out("R10");
    chk("R10", "one record left", 512'({r0_r, r0_e}), 512'(2'b11));
    pull(201, "R10");
    chk("R10", "empty at end", 512'(r0_r), 512'(0));
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrong();
    t_order();
    t_full();
    t_pair();
    summary();
    $finish;
  end
endmodule